// File: doc/BRIEF.md
# Four-Port Command/Indication Change Receiver

The block watches the 4-bit command/indication nibble delivered once per frame on each of four serial line ports. A port's frame strobe marks the cycle in which that port's nibble is valid. A new nibble is accepted only when the same value, different from the value already accepted, arrives in two consecutive frames of that port. A single differing frame is treated as line noise and has no effect on what the CPU sees.

Each accepted nibble is written into a read-only status byte for its port, and the port's pending flag is set. The CPU reads the bytes through a small byte-addressed read port. Read data is combinational from the address. A cycle with the read enable high also clears the addressed port's pending flag at the next clock edge. The interrupt output is high while any pending flag is set and the mask enable is high. A synchronous software reset returns the block to the same state as the hardware reset.

Top module: `ci_change_rx`

## Requirements
- R1: After hardware reset every status byte reads 0x00 and `irq` is low.
- R2: For a port, a nibble that differs from the accepted value is accepted only on the second of two consecutive strobed frames that carry that same nibble. The new byte is visible in the cycle after the second strobe.
- R3: A frame whose nibble equals the accepted value leaves the byte and the pending flag unchanged.
- R4: Status byte layout: bits 3..0 hold the accepted nibble, bit 4 is the pending flag, and bits 7..5 always read 0. Port p is read at address p, for p from 0 to 3.
- R5: A cycle with `rd_en` high returns the addressed byte on `rd_data` in that same cycle and clears that port's pending flag from the next cycle on. The nibble is left unchanged.
- R6: `irq` equals the OR of the four pending flags ANDed with `irq_en`. When `irq_en` is low the pending flags are kept, not cleared.
- R7: If a port accepts a nibble in the same cycle as a read of that port, the pending flag stays set and the next read returns the new nibble.
- R8: An acceptance while the pending flag is already set replaces the stored nibble and leaves the flag set.
- R9: A cycle with `soft_rst` high clears every nibble, every pending flag and every frame history. Afterwards the block behaves as after hardware reset.
- R10: Frames and reads on one port have no effect on any other port's byte.
- R11: Alternating nibbles (A, B, A) are never accepted, because only the immediately previous frame counts as the candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset, active high |
| frame_stb | input | 4 | Per-port frame strobe, bit p for port p |
| frame_ci | input | 16 | Per-port nibble, bits 4p+3..4p for port p |
| rd_en | input | 1 | CPU read strobe, clears the addressed pending flag |
| rd_addr | input | 2 | Byte address, equal to the port index |
| rd_data | output | 8 | Addressed status byte |
| irq_en | input | 1 | Interrupt mask enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a same-cycle collision between a read and an acceptance on one port. It needs a second matching frame and the read strobe aimed at that port in exactly one cycle. Directed sequences set this up by sending the first frame, then the second frame together with the read. Directed sequences also cover the overwrite of a still-pending nibble and the A-B-A pattern. Random traffic, drawn from a small nibble alphabet so that repeated frames are frequent, mixes strobes, reads, mask changes and soft resets across all ports. After every cycle the bench checks all four bytes and `irq` against a bench model.

// File: rtl/ci_rx_pkg.sv
package ci_rx_pkg;
    localparam int CI_W     = 4;
    localparam int BYTE_W   = 8;
    localparam int FULL_BIT = CI_W;

    typedef struct packed {
        logic [CI_W-1:0] cand;
        logic [CI_W-1:0] acc;
        logic            full;
    } ci_port_st_t;
endpackage

// File: rtl/ci_port_filter.sv
module ci_port_filter
    import ci_rx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            stb,
    input  logic [CI_W-1:0] ci,
    input  logic            rd_clr,
    output logic [CI_W-1:0] acc,
    output logic            full
);
    ci_port_st_t st_d, st_q;
    logic        accept;

    always_comb begin
        st_d   = st_q;
        accept = stb && (ci == st_q.cand) && (ci != st_q.acc);
        if (soft_rst) begin
            st_d = '0;
        end else begin
            if (rd_clr) begin
                st_d.full = 1'b0;
            end
            if (stb) begin
                if (accept) begin
                    st_d.acc  = ci;
                    st_d.full = 1'b1;
                end
                st_d.cand = ci;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc  = st_q.acc;
    assign full = st_q.full;
endmodule

// File: rtl/ci_read_mux.sv
module ci_read_mux
    import ci_rx_pkg::*;
#(
    parameter int NPORTS = 4,
    localparam int ADDR_W = $clog2(NPORTS)
) (
    input  logic [NPORTS*CI_W-1:0] acc_flat,
    input  logic [NPORTS-1:0]      full_vec,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [BYTE_W-1:0]      rd_data,
    output logic [NPORTS-1:0]      rd_clr
);
    logic [BYTE_W-1:0] byte_arr [NPORTS];

    for (genvar p = 0; p < NPORTS; p++) begin : g_byte
        always_comb begin
            byte_arr[p]           = '0;
            byte_arr[p][CI_W-1:0] = acc_flat[p*CI_W +: CI_W];
            byte_arr[p][FULL_BIT] = full_vec[p];
        end
        assign rd_clr[p] = rd_en && (rd_addr == ADDR_W'(p));
    end

    assign rd_data = byte_arr[rd_addr];
endmodule

// File: rtl/ci_change_rx.sv
module ci_change_rx
    import ci_rx_pkg::*;
#(
    parameter int NPORTS = 4,
    localparam int ADDR_W = $clog2(NPORTS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_rst,
    input  logic [NPORTS-1:0]      frame_stb,
    input  logic [NPORTS*CI_W-1:0] frame_ci,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [BYTE_W-1:0]      rd_data,
    input  logic                   irq_en,
    output logic                   irq
);
    logic [NPORTS*CI_W-1:0] acc_flat;
    logic [NPORTS-1:0]      full_vec;
    logic [NPORTS-1:0]      rd_clr;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        ci_port_filter u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .stb      (frame_stb[p]),
            .ci       (frame_ci[p*CI_W +: CI_W]),
            .rd_clr   (rd_clr[p]),
            .acc      (acc_flat[p*CI_W +: CI_W]),
            .full     (full_vec[p])
        );
    end

    ci_read_mux #(.NPORTS(NPORTS)) u_mux (
        .acc_flat (acc_flat),
        .full_vec (full_vec),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_clr   (rd_clr)
    );

    assign irq = irq_en && (|full_vec);
endmodule

// File: rtl/ci_change_rx_chk.sv
module ci_change_rx_chk
    import ci_rx_pkg::*;
#(
    parameter int NPORTS = 4,
    localparam int ADDR_W = $clog2(NPORTS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   soft_rst,
    input logic [NPORTS-1:0]      frame_stb,
    input logic                   rd_en,
    input logic [ADDR_W-1:0]      rd_addr,
    input logic [BYTE_W-1:0]      rd_data,
    input logic                   irq_en,
    input logic                   irq,
    input logic [NPORTS-1:0]      full_vec,
    input logic [NPORTS*CI_W-1:0] acc_flat
);
    // R4: reserved bits of every byte read as zero
    p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BYTE_W-1:FULL_BIT+1] == '0);

    // R6: masked interrupt stays low
    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R6: masking keeps the pending flags
    p_mask_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !soft_rst && !rd_en) |=> full_vec == ($past(full_vec) | full_vec));

    // R9: software reset empties every port
    p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (full_vec == '0) && (acc_flat == '0));

    // R5: a read with no frame on that port leaves its flag clear
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !frame_stb[rd_addr]) |=> !full_vec[$past(rd_addr)]);

    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        // R2: a flag rises only after a strobed frame of its own port
        p_rise_needs_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(full_vec[p]) |-> $past(frame_stb[p]));
        // R10: a port's nibble only moves after its own frame or a soft reset
        p_port_isolated_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!frame_stb[p] && !soft_rst) |=> $stable(acc_flat[p*CI_W +: CI_W]));
    end
endmodule

bind ci_change_rx ci_change_rx_chk #(.NPORTS(NPORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .frame_stb (frame_stb),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .irq_en    (irq_en),
    .irq       (irq),
    .full_vec  (full_vec),
    .acc_flat  (acc_flat)
);

// File: tb/ci_change_rx_bench.sv
`timescale 1ns/1ps
module ci_change_rx_bench;
    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [3:0]  frame_stb = '0;
    logic [15:0] frame_ci = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        irq_en = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0] m_cand [NP];
    logic [3:0] m_acc  [NP];
    logic       m_full [NP];

    always #10 clk = ~clk;

    ci_change_rx u_ci_change_rx (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .frame_stb(frame_stb),
        .frame_ci(frame_ci), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_en(irq_en), .irq(irq)
    );

    function automatic logic [7:0] exp_byte(int p);
        return {3'b000, m_full[p], m_acc[p]};
    endfunction

    function automatic logic exp_irq();
        logic any = 1'b0;
        for (int p = 0; p < NP; p++) any |= m_full[p];
        return any & irq_en;
    endfunction

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            m_cand[p] = '0; m_acc[p] = '0; m_full[p] = 1'b0;
        end
    endtask

    task automatic model_step();
        for (int p = 0; p < NP; p++) begin
            logic [3:0] n;
            n = frame_ci[p*4 +: 4];
            if (soft_rst) begin
                m_cand[p] = '0; m_acc[p] = '0; m_full[p] = 1'b0;
            end else begin
                if (rd_en && rd_addr == 2'(p)) m_full[p] = 1'b0;
                if (frame_stb[p]) begin
                    if (n == m_cand[p] && n != m_acc[p]) begin
                        m_acc[p] = n; m_full[p] = 1'b1;
                    end
                    m_cand[p] = n;
                end
            end
        end
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // inputs already set at negedge; look at every port without reading
    task automatic check_all(string req);
        logic       sv_en;
        logic [1:0] sv_a;
        sv_en = rd_en; sv_a = rd_addr;
        rd_en = 1'b0;
        for (int p = 0; p < NP; p++) begin
            rd_addr = 2'(p);
            #1;
            chk(req, rd_data, exp_byte(p));
        end
        chk({req, " irq R6"}, {7'd0, irq}, {7'd0, exp_irq()});
        rd_en = sv_en; rd_addr = sv_a;
    endtask

    // one clock with the given inputs, then compare all ports
    task automatic cyc(logic [3:0] stb, logic [15:0] ci, logic rd, logic [1:0] a,
                       logic srst, string req);
        frame_stb = stb; frame_ci = ci; rd_en = rd; rd_addr = a; soft_rst = srst;
        #1;
        if (rd) chk({req, " read data R5"}, rd_data, exp_byte(int'(a)));
        @(posedge clk);
        model_step();
        @(negedge clk);
        frame_stb = '0; rd_en = 1'b0; soft_rst = 1'b0;
        check_all(req);
    endtask

    function automatic logic [15:0] on(int p, logic [3:0] n);
        logic [15:0] v = '0;
        v[p*4 +: 4] = n;
        return v;
    endfunction

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd2024);
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // R2: one frame is not enough, two are
        irq_en = 1'b1;
        cyc(4'b0001, on(0, 4'h5), 0, 0, 0, "R2 first frame");
        chk("R2 no accept yet", m_full[0] ? 8'hFF : 8'h00, 8'h00);
        cyc(4'b0001, on(0, 4'h5), 0, 0, 0, "R2 second frame");
        chk("R2 byte R4", m_acc[0] == 4'h5 ? 8'h15 : 8'h00, 8'h15);
        // R6: masking hides irq and keeps flag
        irq_en = 1'b0;
        cyc(4'b0000, '0, 0, 0, 0, "R6 masked");
        irq_en = 1'b1;
        cyc(4'b0000, '0, 0, 0, 0, "R6 unmasked");
        // R5: read clears flag, keeps nibble
        cyc(4'b0000, '0, 1, 0, 0, "R5 read clear");
        // R3: same value again does not re-flag
        cyc(4'b0001, on(0, 4'h5), 0, 0, 0, "R3 repeat");
        cyc(4'b0001, on(0, 4'h5), 0, 0, 0, "R3 repeat");
        // R11: A,B,A on port 1
        cyc(4'b0010, on(1, 4'hA), 0, 0, 0, "R11 A");
        cyc(4'b0010, on(1, 4'hB), 0, 0, 0, "R11 B");
        cyc(4'b0010, on(1, 4'hA), 0, 0, 0, "R11 A again");
        // R7: collision on port 2
        cyc(4'b0100, on(2, 4'h9), 0, 0, 0, "R7 first");
        cyc(4'b0100, on(2, 4'h9), 1, 2, 0, "R7 collide");
        cyc(4'b0000, '0, 1, 2, 0, "R7 reread");
        // R8: overwrite while pending on port 3
        cyc(4'b1000, on(3, 4'h3), 0, 0, 0, "R8 a");
        cyc(4'b1000, on(3, 4'h3), 0, 0, 0, "R8 a2");
        cyc(4'b1000, on(3, 4'hC), 0, 0, 0, "R8 c");
        cyc(4'b1000, on(3, 4'hC), 0, 0, 0, "R8 c2");
        // R10: read of port 3 leaves others
        cyc(4'b0000, '0, 1, 3, 0, "R10 isolated read");
        // R9: software reset
        cyc(4'b0000, '0, 0, 0, 1, "R9 soft reset");
        cyc(4'b0001, on(0, 4'h0), 0, 0, 0, "R9 zero after reset");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] ci;
            for (int p = 0; p < NP; p++) ci[p*4 +: 4] = 4'($urandom_range(0, 2) * 5);
            irq_en = ($urandom_range(0, 7) != 0);
            cyc(4'($urandom), ci, ($urandom_range(0, 3) == 0), 2'($urandom),
                ($urandom_range(0, 199) == 0), "R10 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule